// File: doc/BRIEF.md
# Parallel-Port Configuration Loader Bridge

This block connects a host printer-style parallel port, which sends bytes as compatibility-mode strobe/busy/acknowledge write cycles, to the slave parallel configuration port of an FPGA. A rising edge on the host start line resets the target with a program pulse and waits for the target to report that it is ready. From then on, each byte the host strobes in is latched and presented to the target on an 8-bit bus, with chip-select and write-enable asserted and one rising edge of the configuration clock. A byte counter that the host can read gives the number of bytes the target actually took.

The target often raises its done pin a few bytes before the end of the file. The bridge treats this as normal. It finishes the byte in flight and deasserts chip-select and write-enable. It then issues a fixed number of extra configuration clock pulses so that the target's startup sequence can finish. Host bytes that arrive after done still get a full busy/acknowledge handshake, but nothing is written to the target. When startup is complete, the bridge drops the enable of its host status drivers, so the configured device can use those lines.

If the target pulls init low during loading, the bridge reports an error to the host and stops writing. Only a new start request restarts configuration, and only a new start request leaves the released state.

Top module: `ppcfg_loader`

## Requirements
- R1: While `rst` is high and right after it: `tgt_prog_n`, `tgt_cs_n` and `tgt_wr_n` are 1, `tgt_cclk` is 0, `host_busy` is 0, `host_nack_n` is 1, `host_err` and `host_ready` are 0, `host_stat_oe` is 1 and `byte_count` is 0.
- R2: A rising edge on `host_start` drives `tgt_prog_n` low for exactly PROG_CYC cycles (default 8). `host_ready` stays 0 until `tgt_init_n` is seen high after the pulse, and then rises with `tgt_cs_n` driven low.
- R3: A falling edge on `host_nstrobe` latches `host_data` and raises `host_busy`. The bridge then drives `host_nack_n` low for exactly ACK_CYC cycles (default 4) and drops `host_busy` in the cycle `host_nack_n` returns high. `host_nack_n` is never low while `host_busy` is 0.
- R4: Each byte accepted while loading produces exactly one `tgt_cclk` rising edge with `tgt_cs_n` and `tgt_wr_n` low and `tgt_data` equal to that byte, in the order the host sent the bytes.
- R5: Every `tgt_cclk` high phase and every low phase between pulses lasts at least CCLK_HALF cycles (default 2). For a byte write, `tgt_wr_n` is low and `tgt_data` is stable in the cycle before the rising edge and in the cycle after it.
- R6: `byte_count` equals the number of bytes written to the target since the last start request. It clears on a start request and steps by exactly one for each write.
- R7: After `tgt_done` is high, further host bytes still complete the R3 handshake. They cause no `tgt_cclk` edge with `tgt_cs_n` low and leave `byte_count` unchanged.
- R8: After `tgt_done` rises, the bridge holds `tgt_cs_n` and `tgt_wr_n` high and gives exactly STARTUP_CLKS (default 4, at least 2) further `tgt_cclk` pulses.
- R9: When those pulses are done, `host_stat_oe` goes to 0 and `tgt_cclk` stays low. This state lasts until a start request, which sets `host_stat_oe` back to 1.
- R10: If `tgt_init_n` goes low while loading, `host_err` goes to 1 and `tgt_cs_n` goes high. Later bytes are handshaked but not written, and `byte_count` is unchanged. A start request clears `host_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_start | input | 1 | Host start request; the rising edge begins configuration |
| host_nstrobe | input | 1 | Host data strobe, active low |
| host_data | input | 8 | Host data byte |
| host_busy | output | 1 | Busy status to the host |
| host_nack_n | output | 1 | Acknowledge pulse to the host, active low |
| host_err | output | 1 | Configuration error status to the host |
| host_ready | output | 1 | Target ready for data bytes |
| host_stat_oe | output | 1 | Output enable of the host status drivers; 0 releases the lines |
| byte_count | output | CNT_W | Bytes written to the target since the last start |
| tgt_prog_n | output | 1 | Target program line, active low |
| tgt_cs_n | output | 1 | Target chip-select, active low |
| tgt_wr_n | output | 1 | Target write-enable, active low |
| tgt_cclk | output | 1 | Target configuration clock |
| tgt_data | output | 8 | Target configuration data bus |
| tgt_init_n | input | 1 | Target init status, active low |
| tgt_done | input | 1 | Target done status |

## Verification
The bound checker watches the clock and write timing on every cycle: the minimum high and low phases, write-enable and data set up before each write edge and held after it, and chip-select never low while program is low. It also watches the acknowledge pulse, which must fall inside busy, the counter, which may only step by one or clear, chip-select, which stays high during an error, and the released state, which must have done high and the select lines idle. Whether done arriving early leaves exactly the right number of bytes written and startup pulses given, whether late bytes are dropped, and whether an init failure halts loading can only be shown by the bench. It does this with a behavioural target model over a full sweep of all 256 byte values and over short error and early-done sessions.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_PROG,
    LD_WAIT_INIT,
    LD_LOAD,
    LD_STARTUP,
    LD_RELEASED,
    LD_ERROR
  } ld_state_t;

  typedef enum logic [1:0] {
    CG_IDLE,
    CG_SETUP,
    CG_HIGH,
    CG_LOW
  } cg_state_t;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WAIT,
    HS_ACK
  } hs_state_t;

endpackage

// File: rtl/ppcfg_sync.sv
module ppcfg_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ppcfg_host_hs.sv
module ppcfg_host_hs
  import ppcfg_pkg::*;
#(
  parameter int ACK_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_n_s,
  input  logic [7:0] data_in,
  input  logic       take,
  output logic       req,
  output logic       busy,
  output logic       nack_n,
  output logic [7:0] data_q
);

  localparam int AW = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;
  localparam logic [AW-1:0] ACK_LAST = AW'(ACK_CYC - 1);

  hs_state_t     hs;
  logic          strobe_prev;
  logic [AW-1:0] cnt;
  logic          fall;

  assign fall = strobe_prev & ~strobe_n_s;
  assign req  = (hs == HS_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs          <= HS_IDLE;
      strobe_prev <= 1'b1;
      busy        <= 1'b0;
      nack_n      <= 1'b1;
      cnt         <= '0;
      data_q      <= '0;
    end else begin
      strobe_prev <= strobe_n_s;
      case (hs)
        HS_IDLE: if (fall) begin
          data_q <= data_in;
          busy   <= 1'b1;
          hs     <= HS_WAIT;
        end
        HS_WAIT: if (take) begin
          nack_n <= 1'b0;
          cnt    <= '0;
          hs     <= HS_ACK;
        end
        HS_ACK: begin
          if (cnt == ACK_LAST) begin
            nack_n <= 1'b1;
            busy   <= 1'b0;
            hs     <= HS_IDLE;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        default: hs <= HS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ppcfg_cclk_gen.sv
module ppcfg_cclk_gen
  import ppcfg_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go_write,
  input  logic go_pulse,
  output logic cclk,
  output logic wr_act,
  output logic busy,
  output logic done,
  output logic wrise
);

  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] PH_LAST = HW'(HALF - 1);

  cg_state_t     cst;
  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cst    <= CG_IDLE;
      cnt    <= '0;
      cclk   <= 1'b0;
      wr_act <= 1'b0;
    end else begin
      case (cst)
        CG_IDLE: begin
          cnt <= '0;
          if (go_write) begin
            wr_act <= 1'b1;
            cst    <= CG_SETUP;
          end else if (go_pulse) begin
            cclk <= 1'b1;
            cst  <= CG_HIGH;
          end
        end
        CG_SETUP: begin
          cclk <= 1'b1;
          cnt  <= '0;
          cst  <= CG_HIGH;
        end
        CG_HIGH: begin
          if (cnt == PH_LAST) begin
            cclk   <= 1'b0;
            wr_act <= 1'b0;
            cnt    <= '0;
            cst    <= CG_LOW;
          end else begin
            cnt <= cnt + HW'(1);
          end
        end
        CG_LOW: begin
          if (cnt == PH_LAST) begin
            cnt <= '0;
            cst <= CG_IDLE;
          end else begin
            cnt <= cnt + HW'(1);
          end
        end
        default: cst <= CG_IDLE;
      endcase
    end
  end

  assign busy  = (cst != CG_IDLE);
  assign done  = (cst == CG_LOW) && (cnt == PH_LAST);
  assign wrise = (cst == CG_SETUP);

endmodule

// File: rtl/ppcfg_loader.sv
module ppcfg_loader
  import ppcfg_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int CCLK_HALF    = 2,
  parameter int ACK_CYC      = 4,
  parameter int PROG_CYC     = 8,
  parameter int STARTUP_CLKS = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_start,
  input  logic             host_nstrobe,
  input  logic [7:0]       host_data,
  output logic             host_busy,
  output logic             host_nack_n,
  output logic             host_err,
  output logic             host_ready,
  output logic             host_stat_oe,
  output logic [CNT_W-1:0] byte_count,
  output logic             tgt_prog_n,
  output logic             tgt_cs_n,
  output logic             tgt_wr_n,
  output logic             tgt_cclk,
  output logic [7:0]       tgt_data,
  input  logic             tgt_init_n,
  input  logic             tgt_done
);

  localparam int PW = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
  localparam int SW = $clog2(STARTUP_CLKS + 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);
  localparam logic [SW-1:0] SC_END    = SW'(STARTUP_CLKS);

  // synchronised inputs: [3] start, [2] strobe_n, [1] init_n, [0] done
  logic [3:0] sync_q;
  logic       start_s, strobe_s, init_s, done_s;

  ppcfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_start, host_nstrobe, tgt_init_n, tgt_done}),
    .q   (sync_q)
  );
  assign {start_s, strobe_s, init_s, done_s} = sync_q;

  ld_state_t      state, state_n;
  logic           start_prev, start_rise;
  logic [PW-1:0]  pc;
  logic [SW-1:0]  sc;
  logic           pending;
  logic           req, take, discard, go_write, go_pulse, loading;
  logic [7:0]     hs_data;
  logic           cg_busy, cg_done, cg_wrise, cg_cclk, cg_wr;

  ppcfg_host_hs #(.ACK_CYC(ACK_CYC)) u_hs (
    .clk        (clk),
    .rst        (rst),
    .strobe_n_s (strobe_s),
    .data_in    (host_data),
    .take       (take),
    .req        (req),
    .busy       (host_busy),
    .nack_n     (host_nack_n),
    .data_q     (hs_data)
  );

  ppcfg_cclk_gen #(.HALF(CCLK_HALF)) u_cg (
    .clk      (clk),
    .rst      (rst),
    .go_write (go_write),
    .go_pulse (go_pulse),
    .cclk     (cg_cclk),
    .wr_act   (cg_wr),
    .busy     (cg_busy),
    .done     (cg_done),
    .wrise    (cg_wrise)
  );

  assign tgt_cclk   = cg_cclk;
  assign tgt_wr_n   = ~cg_wr;
  assign start_rise = start_s & ~start_prev;
  assign loading    = (state == LD_LOAD) && init_s && !done_s;
  assign go_write   = loading && req && !pending && !cg_busy && !start_rise;
  assign go_pulse   = (state == LD_STARTUP) && !cg_busy && (sc < SC_END) && !start_rise;
  assign discard    = req && !pending && !loading;
  assign take       = (pending && cg_done) || discard;

  always_comb begin
    state_n = state;
    case (state)
      LD_PROG:      if (pc == PROG_LAST) state_n = LD_WAIT_INIT;
      LD_WAIT_INIT: if (init_s) state_n = LD_LOAD;
      LD_LOAD: begin
        if (!init_s)                               state_n = LD_ERROR;
        else if (done_s && !pending && !cg_busy)   state_n = LD_STARTUP;
      end
      LD_STARTUP:   if (sc == SC_END && !cg_busy) state_n = LD_RELEASED;
      default:      state_n = state;
    endcase
    if (start_rise) state_n = LD_PROG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= LD_IDLE;
      start_prev   <= 1'b0;
      pc           <= '0;
      sc           <= '0;
      pending      <= 1'b0;
      tgt_data     <= '0;
      byte_count   <= '0;
      tgt_prog_n   <= 1'b1;
      tgt_cs_n     <= 1'b1;
      host_ready   <= 1'b0;
      host_err     <= 1'b0;
      host_stat_oe <= 1'b1;
    end else begin
      state      <= state_n;
      start_prev <= start_s;

      if (start_rise || state != LD_PROG) pc <= '0;
      else                                pc <= pc + PW'(1);

      if (state != LD_STARTUP) sc <= '0;
      else if (cg_done)        sc <= sc + SW'(1);

      if (go_write)     pending <= 1'b1;
      else if (cg_done) pending <= 1'b0;

      if (go_write) tgt_data <= hs_data;

      if (start_rise)    byte_count <= '0;
      else if (cg_wrise) byte_count <= byte_count + CNT_W'(1);

      tgt_prog_n   <= (state_n != LD_PROG);
      tgt_cs_n     <= (state_n != LD_LOAD);
      host_ready   <= (state_n == LD_LOAD);
      host_err     <= (state_n == LD_ERROR);
      host_stat_oe <= (state_n != LD_RELEASED);
    end
  end

endmodule

// File: rtl/ppcfg_loader_chk.sv
module ppcfg_loader_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             host_busy,
  input logic             host_nack_n,
  input logic             host_err,
  input logic             host_stat_oe,
  input logic [CNT_W-1:0] byte_count,
  input logic             tgt_prog_n,
  input logic             tgt_cs_n,
  input logic             tgt_wr_n,
  input logic             tgt_cclk,
  input logic [7:0]       tgt_data,
  input logic             tgt_done
);

  assert_cs_after_prog_R2: assert property (@(posedge clk) disable iff (rst)
    !tgt_cs_n |-> tgt_prog_n);

  assert_ack_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
    !host_nack_n |-> host_busy);

  assert_wr_setup_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(tgt_cclk) && !tgt_wr_n) |-> (!$past(tgt_wr_n) && $stable(tgt_data)));

  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(tgt_cclk) && !tgt_wr_n) |=> (!tgt_wr_n && $stable(tgt_data)));

  assert_high_min_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_cclk) |=> tgt_cclk);

  assert_low_min_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_cclk) |=> !tgt_cclk);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_count != $past(byte_count)) |->
      (byte_count == $past(byte_count) + CNT_W'(1) || byte_count == '0));

  assert_release_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !host_stat_oe |-> (tgt_cs_n && tgt_wr_n));

  assert_release_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(host_stat_oe) |-> tgt_done);

  assert_err_no_select_R10: assert property (@(posedge clk) disable iff (rst)
    host_err |-> tgt_cs_n);

endmodule

bind ppcfg_loader ppcfg_loader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_busy    (host_busy),
  .host_nack_n  (host_nack_n),
  .host_err     (host_err),
  .host_stat_oe (host_stat_oe),
  .byte_count   (byte_count),
  .tgt_prog_n   (tgt_prog_n),
  .tgt_cs_n     (tgt_cs_n),
  .tgt_wr_n     (tgt_wr_n),
  .tgt_cclk     (tgt_cclk),
  .tgt_data     (tgt_data),
  .tgt_done     (tgt_done)
);

// File: tb/ppcfg_loader_tb.sv
module ppcfg_loader_tb;

  localparam int CNT_W   = 20;
  localparam int ACK_CYC = 4;
  localparam int PROG_CYC = 8;
  localparam int SU_CLKS = 4;
  localparam int HALF    = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             host_start, host_nstrobe;
  logic [7:0]       host_data;
  logic             host_busy, host_nack_n, host_err, host_ready, host_stat_oe;
  logic [CNT_W-1:0] byte_count;
  logic             tgt_prog_n, tgt_cs_n, tgt_wr_n, tgt_cclk;
  logic [7:0]       tgt_data;
  logic             tgt_init_n, tgt_done;

  always #4 clk = ~clk;

  ppcfg_loader #(
    .CNT_W(CNT_W), .CCLK_HALF(HALF), .ACK_CYC(ACK_CYC),
    .PROG_CYC(PROG_CYC), .STARTUP_CLKS(SU_CLKS), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .host_start(host_start), .host_nstrobe(host_nstrobe),
    .host_data(host_data), .host_busy(host_busy), .host_nack_n(host_nack_n),
    .host_err(host_err), .host_ready(host_ready), .host_stat_oe(host_stat_oe),
    .byte_count(byte_count), .tgt_prog_n(tgt_prog_n), .tgt_cs_n(tgt_cs_n),
    .tgt_wr_n(tgt_wr_n), .tgt_cclk(tgt_cclk), .tgt_data(tgt_data),
    .tgt_init_n(tgt_init_n), .tgt_done(tgt_done)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural target model ----------------
  int  session = 1;
  int  done_at = 1000000;
  bit  force_init_low = 0;
  int  nwr = 0, startup_rises = 0, late_wr = 0, icnt = 0;
  int  hi_run = 0, lo_run = 0, min_hi = 1000, min_lo = 1000;
  bit  had_pulse = 0, hold_pend = 0;
  logic [7:0] hold_data;
  logic prev_cclk = 1'b0, prev_wr_n = 1'b1;
  logic [7:0] prev_data = '0;

  function automatic logic [7:0] exp_byte(input int sess, input int idx);
    return (sess == 2) ? (8'(idx) ^ 8'hA5) : 8'(idx);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      tgt_init_n = 1'b1; tgt_done = 1'b0; icnt = 0;
    end else begin
      if (hold_pend) begin
        check(!tgt_wr_n && tgt_data == hold_data, "R5 hold", tgt_data, hold_data);
        hold_pend = 0;
      end
      if (tgt_cclk && !prev_cclk) begin
        if (had_pulse && lo_run < min_lo) min_lo = lo_run;
        had_pulse = 1; hi_run = 0;
        if (!tgt_cs_n && !tgt_wr_n) begin
          if (tgt_done) late_wr++;
          else begin
            check(tgt_data == exp_byte(session, nwr), "R4 data", tgt_data, exp_byte(session, nwr));
            check(!prev_wr_n && prev_data == tgt_data, "R5 setup", prev_data, tgt_data);
            nwr++;
            hold_pend = 1; hold_data = tgt_data;
          end
        end else if (tgt_done && tgt_cs_n && tgt_wr_n) begin
          startup_rises++;
        end
      end
      if (!tgt_cclk && prev_cclk) begin
        if (hi_run < min_hi) min_hi = hi_run;
        lo_run = 0;
      end
      if (tgt_cclk) hi_run++; else lo_run++;
      if (!tgt_prog_n) begin
        tgt_init_n = 1'b0; tgt_done = 1'b0; icnt = 0;
        nwr = 0; startup_rises = 0; late_wr = 0;
      end else begin
        if (icnt < 5) icnt++;
        else tgt_init_n = !force_init_low;
        if (tgt_init_n && nwr >= done_at) tgt_done = 1'b1;
      end
      prev_cclk = tgt_cclk; prev_wr_n = tgt_wr_n; prev_data = tgt_data;
    end
  end

  // ---------------- host tasks ----------------
  task automatic do_start();
    int prog_low = 0;
    bit bad = 0, seen = 0;
    host_start = 1'b1;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (c == 4) host_start = 1'b0;
      if (!tgt_prog_n) prog_low++;
      if (host_ready && !tgt_init_n) bad = 1;
      if (host_ready && c > 4) begin seen = 1; break; end
    end
    host_start = 1'b0;
    check(prog_low == PROG_CYC, "R2 program pulse", prog_low, PROG_CYC);
    check(!bad, "R2 ready before init", bad, 0);
    check(seen && !tgt_cs_n, "R2 ready and select", tgt_cs_n, 0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    int nl = 0;
    bit sb = 0, ok = 0;
    host_data = b;
    @(negedge clk);
    host_nstrobe = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (c == 3) host_nstrobe = 1'b1;
      if (!host_nack_n) nl++;
      if (host_busy) sb = 1;
      if (sb && !host_busy && c > 3) begin ok = 1; break; end
    end
    host_nstrobe = 1'b1;
    check(ok && nl == ACK_CYC, "R3 handshake ack width", nl, ACK_CYC);
  endtask

  task automatic wait_release(output bit ok);
    ok = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (!host_stat_oe) begin ok = 1; break; end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    bit ok;
    int su_before;
    rst = 1'b1; host_start = 1'b0; host_nstrobe = 1'b1; host_data = '0;
    repeat (5) @(negedge clk);
    check(tgt_prog_n && tgt_cs_n && tgt_wr_n && !tgt_cclk, "R1 target lines in reset", tgt_cclk, 0);
    rst = 1'b0;
    @(negedge clk);
    check(tgt_prog_n && tgt_cs_n && tgt_wr_n && !tgt_cclk, "R1 target lines", {tgt_prog_n, tgt_cs_n, tgt_wr_n, tgt_cclk}, 4'b1110);
    check(!host_busy && host_nack_n && !host_err && !host_ready, "R1 host lines",
          {host_busy, host_nack_n, host_err, host_ready}, 4'b0100);
    check(host_stat_oe && byte_count == 0, "R1 enable and count", byte_count, 0);

    // session 1: full byte sweep, done rises 6 bytes early
    session = 1; done_at = 250;
    do_start();
    for (int i = 0; i < 256; i++) send_byte(exp_byte(1, i));
    wait_release(ok);
    check(ok, "R9 release after startup", host_stat_oe, 0);
    check(nwr == 250, "R4 bytes written", nwr, 250);
    check(byte_count == 250, "R6 byte count", byte_count, 250);
    check(late_wr == 0, "R7 no write after done", late_wr, 0);
    check(startup_rises == SU_CLKS, "R8 startup pulses", startup_rises, SU_CLKS);
    check(tgt_cs_n && tgt_wr_n, "R8 select idle", {tgt_cs_n, tgt_wr_n}, 2'b11);
    check(min_hi >= HALF, "R5 high phase", min_hi, HALF);
    check(min_lo >= HALF, "R5 low phase", min_lo, HALF);
    su_before = startup_rises;
    repeat (40) @(negedge clk);
    check(!host_stat_oe && !tgt_cclk && startup_rises == su_before, "R9 stays released",
          startup_rises, su_before);
    send_byte(8'h3C);
    check(byte_count == 250 && late_wr == 0, "R7 late byte dropped", byte_count, 250);

    // session 2: init failure during loading
    session = 2; done_at = 1000000;
    do_start();
    check(host_stat_oe && byte_count == 0 && !host_err, "R9 start re-enables", byte_count, 0);
    for (int i = 0; i < 10; i++) send_byte(exp_byte(2, i));
    force_init_low = 1;
    ok = 0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (host_err) begin ok = 1; break; end
    end
    check(ok && tgt_cs_n, "R10 error flagged", host_err, 1);
    for (int i = 10; i < 13; i++) send_byte(exp_byte(2, i));
    check(nwr == 10, "R10 no writes in error", nwr, 10);
    check(byte_count == 10, "R10 count frozen", byte_count, 10);
    check(host_err, "R10 error held", host_err, 1);
    force_init_low = 0;
    session = 3; done_at = 3;
    do_start();
    check(!host_err && byte_count == 0, "R10 start clears error", host_err, 0);

    // session 3: very short file, done after 3 bytes
    for (int i = 0; i < 5; i++) send_byte(exp_byte(3, i));
    wait_release(ok);
    check(ok, "R9 release short file", host_stat_oe, 0);
    check(byte_count == 3, "R6 short count", byte_count, 3);
    check(late_wr == 0, "R7 short no late write", late_wr, 0);
    check(startup_rises == SU_CLKS, "R8 short startup pulses", startup_rises, SU_CLKS);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule